// File: doc/BRIEF.md
# Clock Calendar Time Registers

This block keeps the calendar time of a clock peripheral in eight byte registers: seconds, minutes, hours, weekday, day of month, month, a two-digit year and a century. A one-cycle pulse on `sec_tick` moves the time forward by one second. The carries ripple through the fields, and month lengths and leap years are applied. Software reaches every register through a byte-wide port. Reads are combinational. A read strobe marks the cycle in which status side effects take place.

The `bin_mode` input selects the number format. When it is high, all fields hold plain binary values. When it is low, they hold packed BCD, with the tens digit in the upper nibble. Each field is advanced in whichever format is in force when the tick arrives. A freeze bit in control register B stops the advance so that software can load a new time. While it is set, the stored bytes are returned exactly as they were written.

The status registers report an update-in-progress bit and an update-ended flag. The first is cleared by each tick. The second is set by each tick and is acknowledged by reading the status register. A validity register always reports good time.

Top module: `rtc_time_regs`

## Requirements
- R1: Reset gives the following values: seconds, minutes, hours and year 0; weekday, day and month 1; century 20, all in the selected format. Update-in-progress reads 1, the update-ended flag reads 0, and the freeze bit is 0.
- R2: The register addresses are: 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year, 7 century. On a tick with the freeze bit clear, seconds go up by one. Seconds wrap 59 to 0 and carry into minutes. Minutes wrap 59 to 0 and carry into hours. Hours wrap 23 to 0 and carry into day and weekday. Day carries into month, and month wraps 12 to 1 and carries into year.
- R3: Day wraps to 1 after 31 in months 1, 3, 5, 7, 8, 10 and 12, and after 30 in months 4, 6, 9 and 11. In month 2, day wraps after 29 when the two-digit year is divisible by 4, and after 28 otherwise.
- R4: Weekday advances on each day carry and wraps from 7 back to 1.
- R5: With `bin_mode` low, every field is held and advanced as BCD, encoded as (v/10)*16 + v%10. With `bin_mode` high, every field is plain binary. Bit 2 of control register B (address 9) reads 1 in binary mode and 0 in BCD mode.
- R6: While bit 7 of control register B is 1, ticks leave all eight time registers unchanged. Written bytes, including invalid BCD digits, read back unmodified.
- R7: The year wraps from 99 to 0 and adds one to the century register.
- R8: Bit 7 of register A (address 8) is update-in-progress. A tick clears it. The next read of register A returns 0, and that read sets the bit back to 1.
- R9: Bit 4 of status register C (address 10) is the update-ended flag, and bit 7 mirrors it. A tick sets the flag even while time is frozen. A read of C clears the flag after returning it. If a tick coincides with a read of C, the flag stays set.
- R10: Register D (address 11) always reads 0x80. Writes to registers A, C and D change nothing.
- R11: A write to a time register in the same cycle as a tick stores the written byte in that field. The other fields still advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| bin_mode | input | 1 | 1 selects binary values, 0 selects BCD |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (triggers status side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| uip | output | 1 | Update-in-progress bit |
| update_flag | output | 1 | Update-ended flag |

## Verification
Two pairs of events can land on the same edge: a tick together with a read of the status register, and a tick together with a software write to one time field. The bench drives both strobes in one cycle. It then reads back the status register and expects the flag still set. It also reads back the written field and its neighbour, expecting the written byte in one and the advanced value in the other.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NFIELD = 8;
  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_WDAY = 3;
  localparam int F_MDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;
  localparam int F_CENT = 7;
  localparam int R_CTLA = 8;
  localparam int R_CTLB = 9;
  localparam int R_STAT = 10;
  localparam int R_VALD = 11;

  function automatic logic [7:0] to_bcd(input logic [6:0] v);
    logic [3:0] tens, ones;
    tens = 4'((v / 7'd10));
    ones = 4'((v % 7'd10));
    return {tens, ones};
  endfunction

  function automatic logic [7:0] from_bcd(input logic [7:0] b);
    return 8'(b[7:4] * 8'd10) + {4'd0, b[3:0]};
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    return bin ? {1'b0, v} : to_bcd(v);
  endfunction

  function automatic logic [7:0] dec(input logic [7:0] b, input logic bin);
    return bin ? b : from_bcd(b);
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'd2:                       return (yr[1:0] == 2'd0) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:    return 8'd30;
      default:                    return 8'd31;
    endcase
  endfunction

  function automatic logic [6:0] reset_value(input int f);
    case (f)
      F_WDAY, F_MDAY, F_MON: return 7'd1;
      F_CENT:                return 7'd20;
      default:               return 7'd0;
    endcase
  endfunction
endpackage

// File: rtl/rtc_field.sv
module rtc_field
  import rtc_pkg::*;
(
  input  logic [7:0] cur,
  input  logic       bin,
  input  logic       cin,
  input  logic [7:0] lo,
  input  logic [7:0] hi,
  output logic [7:0] nxt,
  output logic       cout
);
  logic [7:0] val;
  logic [7:0] inc;
  logic       wrap;

  always_comb begin
    val  = dec(cur, bin);
    wrap = (val >= hi);
    inc  = wrap ? lo : val + 8'd1;
    nxt  = cin ? enc(inc[6:0], bin) : cur;
    cout = cin & wrap;
  end
endmodule

// File: rtl/rtc_status.sv
module rtc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic ack_a,
  input  logic ack_c,
  output logic uip,
  output logic uf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip <= 1'b1;
      uf  <= 1'b0;
    end else begin
      if (tick)       uip <= 1'b0;
      else if (ack_a) uip <= 1'b1;
      if (tick)       uf  <= 1'b1;
      else if (ack_c) uf  <= 1'b0;
    end
  end

  AST_UIP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !uip); // R8
  AST_UIP_RESTORED: assert property (@(posedge clk) disable iff (!rst_n) (ack_a && !tick) |=> uip); // R8
  AST_UF_RAISED: assert property (@(posedge clk) disable iff (!rst_n) tick |=> uf); // R9
  AST_UF_ACKED: assert property (@(posedge clk) disable iff (!rst_n) (ack_c && !tick) |=> !uf); // R9
endmodule

// File: rtl/rtc_time_regs.sv
module rtc_time_regs
  import rtc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              bin_mode,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              uip,
  output logic              update_flag
);
  localparam int FLAT_W = NFIELD * 8;

  logic [7:0]        fld_q   [NFIELD];
  logic [7:0]        fld_nxt [NFIELD];
  logic [7:0]        fld_lo  [NFIELD];
  logic [7:0]        fld_hi  [NFIELD];
  logic [NFIELD-1:0] cin, cout, wr_hit;
  logic [FLAT_W-1:0] time_flat;
  logic              set_q;
  logic              adv_en;
  logic              ack_a, ack_c;

  assign adv_en = sec_tick & ~set_q;
  assign ack_a  = reg_rd && (reg_addr == ADDR_W'(R_CTLA));
  assign ack_c  = reg_rd && (reg_addr == ADDR_W'(R_STAT));

  // carry chain routing and per-field limits
  always_comb begin
    cin[F_SEC]  = adv_en;
    cin[F_MIN]  = cout[F_SEC];
    cin[F_HOUR] = cout[F_MIN];
    cin[F_WDAY] = cout[F_HOUR];
    cin[F_MDAY] = cout[F_HOUR];
    cin[F_MON]  = cout[F_MDAY];
    cin[F_YEAR] = cout[F_MON];
    cin[F_CENT] = cout[F_YEAR];
    for (int i = 0; i < NFIELD; i++) begin
      fld_lo[i] = 8'(reset_value(i));
      if (i == F_CENT) fld_lo[i] = 8'd0;
    end
    fld_hi[F_SEC]  = 8'd59;
    fld_hi[F_MIN]  = 8'd59;
    fld_hi[F_HOUR] = 8'd23;
    fld_hi[F_WDAY] = 8'd7;
    fld_hi[F_MDAY] = month_len(dec(fld_q[F_MON], bin_mode), dec(fld_q[F_YEAR], bin_mode));
    fld_hi[F_MON]  = 8'd12;
    fld_hi[F_YEAR] = 8'd99;
    fld_hi[F_CENT] = 8'd99;
  end

  for (genvar g = 0; g < NFIELD; g++) begin : g_field
    rtc_field u_fld (
      .cur  (fld_q[g]),
      .bin  (bin_mode),
      .cin  (cin[g]),
      .lo   (fld_lo[g]),
      .hi   (fld_hi[g]),
      .nxt  (fld_nxt[g]),
      .cout (cout[g])
    );
    assign wr_hit[g]         = reg_wr && (reg_addr == ADDR_W'(g));
    assign time_flat[g*8 +: 8] = fld_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NFIELD; i++) fld_q[i] <= enc(reset_value(i), bin_mode);
      set_q <= 1'b0;
    end else begin
      for (int i = 0; i < NFIELD; i++)
        fld_q[i] <= wr_hit[i] ? reg_wdata : fld_nxt[i];
      if (reg_wr && reg_addr == ADDR_W'(R_CTLB)) set_q <= reg_wdata[7];
    end
  end

  rtc_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (sec_tick),
    .ack_a (ack_a),
    .ack_c (ack_c),
    .uip   (uip),
    .uf    (update_flag)
  );

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < NFIELD; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = fld_q[i];
    if (reg_addr == ADDR_W'(R_CTLA)) reg_rdata = {uip, 7'd0};
    if (reg_addr == ADDR_W'(R_CTLB)) reg_rdata = {set_q, 4'd0, bin_mode, 2'd0};
    if (reg_addr == ADDR_W'(R_STAT)) reg_rdata = {update_flag, 2'd0, update_flag, 4'd0};
    if (reg_addr == ADDR_W'(R_VALD)) reg_rdata = 8'h80;
  end

  AST_FROZEN_TIME: assert property (@(posedge clk) disable iff (!rst_n) (set_q && !reg_wr) |=> $stable(time_flat)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!sec_tick && !reg_wr) |=> $stable(time_flat)); // R2
endmodule

// File: tb/rtc_time_regs_test.sv
module rtc_time_regs_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic       bin_mode = 1'b0;
  logic [3:0] reg_addr = 4'd0;
  logic       reg_wr = 1'b0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       uip, update_flag;
  int         n_run = 0;
  int         n_fail = 0;
  logic [7:0] got;

  always #4 clk = ~clk;

  rtc_time_regs #(.ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bin_mode(bin_mode),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .uip(uip), .update_flag(update_flag)
  );

  // byte i = field i : {century, year, month, day, weekday, hour, min, sec}
  localparam int NV = 8;
  localparam logic [63:0] START [NV] = '{
    {8'd20, 8'd24, 8'd6,  8'd15, 8'd3, 8'd10, 8'd20, 8'd30},
    {8'd20, 8'd99, 8'd12, 8'd31, 8'd7, 8'd23, 8'd59, 8'd59},  // R4 R7
    {8'd20, 8'd23, 8'd2,  8'd28, 8'd2, 8'd23, 8'd59, 8'd59},  // R3 plain February
    {8'd20, 8'd24, 8'd2,  8'd28, 8'd4, 8'd23, 8'd59, 8'd59},  // R3 leap February
    {8'd20, 8'd25, 8'd4,  8'd30, 8'd6, 8'd23, 8'd59, 8'd59},  // R3 thirty-day month
    {8'd20, 8'd25, 8'd5,  8'd30, 8'd1, 8'd23, 8'd59, 8'd59},  // R3 long month
    {8'd20, 8'd25, 8'd7,  8'd4,  8'd5, 8'd14, 8'd10, 8'd59},
    {8'd20, 8'd25, 8'd7,  8'd4,  8'd5, 8'd9,  8'd59, 8'd59}
  };
  localparam logic [63:0] EXPECT [NV] = '{
    {8'd20, 8'd24, 8'd6,  8'd15, 8'd3, 8'd10, 8'd20, 8'd31},
    {8'd21, 8'd0,  8'd1,  8'd1,  8'd1, 8'd0,  8'd0,  8'd0},
    {8'd20, 8'd23, 8'd3,  8'd1,  8'd3, 8'd0,  8'd0,  8'd0},
    {8'd20, 8'd24, 8'd2,  8'd29, 8'd5, 8'd0,  8'd0,  8'd0},
    {8'd20, 8'd25, 8'd5,  8'd1,  8'd7, 8'd0,  8'd0,  8'd0},
    {8'd20, 8'd25, 8'd5,  8'd31, 8'd2, 8'd0,  8'd0,  8'd0},
    {8'd20, 8'd25, 8'd7,  8'd4,  8'd5, 8'd14, 8'd11, 8'd0},
    {8'd20, 8'd25, 8'd7,  8'd4,  8'd5, 8'd10, 8'd0,  8'd0}
  };

  function automatic logic [7:0] fmt(input logic [7:0] v, input logic bin);
    return bin ? v : v + 8'd6 * (v / 8'd10);
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    bin_mode = mode; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R1 reset state in BCD mode
    do_reset(1'b0);
    check("R1 uip", {7'd0, uip}, 8'd1);
    check("R1 flag", {7'd0, update_flag}, 8'd0);
    rd(0, got);  check("R1 seconds", got, 8'h00);
    rd(4, got);  check("R1 day", got, 8'h01);
    rd(7, got);  check("R1 century bcd", got, 8'h20);
    rd(9, got);  check("R5 mode bit bcd", got, 8'h00);
    rd(10, got); check("R1 status", got, 8'h00);
    rd(11, got); check("R10 valid", got, 8'h80);
    // R1 reset in binary mode
    do_reset(1'b1);
    rd(7, got);  check("R1 century binary", got, 8'd20);
    rd(9, got);  check("R5 mode bit binary", got, 8'h04);

    // vector table: R2 R3 R4 R5 R7 in both formats
    for (int m = 0; m < 2; m++) begin
      bin_mode = 1'(m);
      for (int v = 0; v < NV; v++) begin
        wr(9, 8'h80);
        for (int f = 0; f < 8; f++) wr(f, fmt(START[v][f*8 +: 8], 1'(m)));
        wr(9, 8'h00);
        tick();
        for (int f = 0; f < 8; f++) begin
          rd(f, got);
          check($sformatf("R2 vec%0d mode%0d field%0d", v, m, f), got,
                fmt(EXPECT[v][f*8 +: 8], 1'(m)));
        end
      end
    end

    do_reset(1'b0);
    // R8 update-in-progress
    tick();
    check("R8 uip after tick", {7'd0, uip}, 8'd0);
    rd(8, got); check("R8 first read", got, 8'h00);
    rd(8, got); check("R8 second read", got, 8'h80);
    // R9 update-ended flag
    rd(10, got); check("R9 flag set", got, 8'h90);
    rd(10, got); check("R9 flag acked", got, 8'h00);
    // R9 tick coincides with status read
    @(negedge clk);
    sec_tick = 1'b1; reg_rd = 1'b1; reg_addr = 4'd10;
    @(negedge clk);
    sec_tick = 1'b0; reg_rd = 1'b0;
    rd(10, got); check("R9 coincident tick keeps flag", got, 8'h90);

    // R6 freeze with invalid BCD
    wr(9, 8'h80);
    wr(0, 8'h5A);
    wr(2, 8'h23);
    tick();
    tick();
    rd(0, got);  check("R6 frozen seconds", got, 8'h5A);
    rd(2, got);  check("R6 frozen hours", got, 8'h23);
    rd(9, got);  check("R6 freeze bit", got, 8'h80);
    rd(10, got); check("R9 flag while frozen", got, 8'h90);

    // R10 writes to A, C, D ignored
    rd(8, got);
    wr(8, 8'h00);  rd(8, got);  check("R10 reg A write", got, 8'h80);
    wr(10, 8'hFF); rd(10, got); check("R10 reg C write", got, 8'h00);
    wr(11, 8'h00); rd(11, got); check("R10 reg D write", got, 8'h80);

    // R11 write and tick in same cycle
    wr(9, 8'h00);
    wr(0, 8'h10);
    wr(1, 8'h05);
    @(negedge clk);
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 8'h33;
    @(negedge clk);
    sec_tick = 1'b0; reg_wr = 1'b0;
    rd(1, got); check("R11 written field", got, 8'h33);
    rd(0, got); check("R11 other field advanced", got, 8'h11);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule